// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, for every incoming Ethernet frame, whether the frame is kept or discarded, looking only at the 48-bit destination address. The address is presented as six bytes on a byte-wide input, the first byte flagged by a start marker. One cycle after the sixth byte the block raises a decision strobe. The strobe carries an accept bit and a class code that says which rule matched.

The filter is configured through a small write port. Its registers hold the station address (a 16-bit upper part and a 32-bit lower part), a mode word and a 64-bit group hash table kept as four 16-bit words. A frame can be accepted for five reasons:

- every frame is accepted in promiscuous mode;
- the all-ones broadcast address is accepted when broadcast accept is on;
- an exact station-address match is accepted when station accept is on;
- any group address is accepted when all-multicast is on;
- a group address is accepted when hashing is on and its hash-table bit is set.

The hash is the Ethernet CRC-32 of the six address bytes. Its top six bits select one table bit.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0 and `dec_class` is 0, and every configuration register is zero, so any frame (including broadcast) is rejected with class 0.
- R2: Write port: `wr_sel` 0 loads the station upper part from `wr_data[15:0]` (address byte 0 in bits 15:8), 1 loads the lower part from `wr_data[31:0]` (byte 2 in bits 31:24), 2 loads the mode word from `wr_data[4:0]`, and 3..6 load hash words 0..3 from `wr_data[15:0]`. Mode bits: bit0 promiscuous, bit1 all-multicast, bit2 hash enable, bit3 broadcast accept, bit4 station accept.
- R3: With hashing on, a group address (bit 0 of byte 0 set) is accepted with class 5 exactly when table bit `idx` is set. The CRC is computed with init 0xFFFFFFFF, polynomial 0x04C11DB7, shifting left, with the data bits of each byte taken LSB first and no final inversion. `idx` is 63 minus CRC bits 31:26. Table bit `idx` is bit `15-(idx%16)` of hash word `idx/16`.
- R4: The hash table is never consulted for individual addresses, nor when hashing is off.
- R5: In promiscuous mode every frame is accepted with class 1.
- R6: With broadcast accept on, the address FF:FF:FF:FF:FF:FF is accepted with class 2.
- R7: With station accept on, an address equal to the station address in all six bytes is accepted with class 3; a difference in any byte does not match.
- R8: With all-multicast on, every group address is accepted with class 4.
- R9: When several rules match, the class reported is the first in this order: promiscuous, broadcast, station, all-multicast, hash. A frame that matches no rule is rejected with class 0.
- R10: `dec_valid` is a one-cycle pulse in the cycle after the sixth address byte is accepted. While `dec_valid` is low, `dec_accept` is 0 and `dec_class` is 0.
- R11: Configuration is sampled when the first address byte is accepted. A register write that lands after that byte does not affect the frame in progress, but it does apply to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R2) |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Address byte valid |
| in_first | input | 1 | Marks the first byte of a destination address |
| in_byte | input | 8 | Address byte, first byte first |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_class | output | 3 | Matching rule: 0 none, 1 promiscuous, 2 broadcast, 3 station, 4 all-multicast, 5 hash |

## Verification
The hardest case to reach from the ports is a hash hit on a chosen table bit, because the bit index is a CRC of the address and cannot be set directly. The bench computes the CRC of each of 64 multicast addresses itself. It programs a table with only that bit set and expects acceptance, then programs the complementary table and expects rejection, so both the CRC and the word and bit numbering are exercised. The configuration-freeze case is reached by stopping a frame after its third byte, rewriting the mode word, and then finishing the frame.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;

   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

   typedef enum logic [2:0] {
      CLS_NONE    = 3'd0,
      CLS_PROMISC = 3'd1,
      CLS_BCAST   = 3'd2,
      CLS_STATION = 3'd3,
      CLS_ALLMC   = 3'd4,
      CLS_HASH    = 3'd5
   } rxf_class_e;

   // bit0 promisc ... bit4 station accept
   typedef struct packed {
      logic sta_en;
      logic bcast_en;
      logic hash_en;
      logic allmc;
      logic promisc;
   } rxf_mode_t;

   // One byte of the Ethernet CRC: left-shifting register, data LSB first.
   function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
      logic [31:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         if (c[31] ^ d[i]) c = {c[30:0], 1'b0} ^ CRC_POLY;
         else              c = {c[30:0], 1'b0};
      end
      return c;
   endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
   import eth_rxf_pkg::*;
#(
   parameter int HASH_W = 64,
   parameter int HREG_W = 16,
   parameter int ADDR_W = 48,
   parameter int SEL_W  = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              snap_load,
   output logic [ADDR_W-1:0] snap_station,
   output rxf_mode_t         snap_mode,
   output logic [HASH_W-1:0] snap_table
);
   localparam int HREGS = HASH_W / HREG_W;
   localparam int SEL_HASH0 = 3;
   localparam int HI_W = ADDR_W - DATA_W;

   logic [HI_W-1:0]   sta_hi_q;
   logic [DATA_W-1:0] sta_lo_q;
   rxf_mode_t         mode_q;
   logic [HASH_W-1:0] table_live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sta_hi_q <= '0;
         sta_lo_q <= '0;
         mode_q   <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_W'(0)) sta_hi_q <= wr_data[HI_W-1:0];
         if (wr_sel == SEL_W'(1)) sta_lo_q <= wr_data;
         if (wr_sel == SEL_W'(2)) mode_q   <= rxf_mode_t'(wr_data[4:0]);
      end
   end

   // Word k holds table bits k*HREG_W .. k*HREG_W+HREG_W-1, MSB first.
   for (genvar k = 0; k < HREGS; k++) begin : g_hash
      logic [HREG_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_en && wr_sel == SEL_W'(SEL_HASH0 + k))
            word_q <= wr_data[HREG_W-1:0];
      end
      assign table_live[HASH_W-1-k*HREG_W -: HREG_W] = word_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_station <= '0;
         snap_mode    <= '0;
         snap_table   <= '0;
      end else if (snap_load) begin
         snap_station <= {sta_hi_q, sta_lo_q};
         snap_mode    <= mode_q;
         snap_table   <= table_live;
      end
   end

   // R11
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_load |=> ($stable(snap_mode) && $stable(snap_table) && $stable(snap_station)));

endmodule

// File: rtl/rxf_crc_acc.sv
module rxf_crc_acc
   import eth_rxf_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int IDX_W      = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_first,
   input  logic [7:0]              in_byte,
   output logic                    last_byte,
   output logic                    frame_start,
   output logic [ADDR_BYTES*8-1:0] full_addr,
   output logic [IDX_W-1:0]        crc_top
);
   localparam int AQ_W  = (ADDR_BYTES - 1) * 8;
   localparam int CNT_W = $clog2(ADDR_BYTES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [31:0]      crc_q;
   logic [31:0]      crc_next;
   logic [AQ_W-1:0]  addr_q;
   logic             advance;

   assign frame_start = in_valid && in_first;
   assign advance     = in_valid && !in_first && busy_q;
   assign last_byte   = advance && (cnt_q == CNT_LAST);
   assign crc_next    = crc_step(in_first ? 32'hFFFF_FFFF : crc_q, in_byte);
   assign full_addr   = {addr_q, in_byte};
   assign crc_top     = crc_next[31 -: IDX_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         crc_q  <= '0;
         addr_q <= '0;
      end else if (frame_start) begin
         cnt_q  <= CNT_W'(1);
         busy_q <= 1'b1;
         crc_q  <= crc_next;
         addr_q <= {{(AQ_W-8){1'b0}}, in_byte};
      end else if (advance) begin
         cnt_q  <= cnt_q + CNT_W'(1);
         busy_q <= (cnt_q != CNT_LAST);
         crc_q  <= crc_next;
         addr_q <= {addr_q[AQ_W-9:0], in_byte};
      end
   end

   // R10
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= CNT_LAST && cnt_q != '0));

   // R10
   last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && !frame_start) |=> !busy_q);

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import eth_rxf_pkg::*;
#(
   parameter int ADDR_W = 48,
   parameter int HASH_W = 64,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              last_byte,
   input  logic [ADDR_W-1:0] addr,
   input  logic [IDX_W-1:0]  crc_top,
   input  logic [ADDR_W-1:0] station,
   input  rxf_mode_t         mode,
   input  logic [HASH_W-1:0] hash_table,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [2:0]        dec_class
);
   rxf_class_e cls_d;
   logic       is_group;
   logic       hash_hit;

   // Group bit is bit 0 of the first address byte.
   assign is_group = addr[ADDR_W-8];
   // Flat table is word0..word3 MSB first, so flat bit = CRC top bits.
   assign hash_hit = hash_table[crc_top];

   always_comb begin
      if (mode.promisc)                          cls_d = CLS_PROMISC;
      else if (mode.bcast_en && (&addr))         cls_d = CLS_BCAST;
      else if (mode.sta_en && addr == station)   cls_d = CLS_STATION;
      else if (is_group && mode.allmc)           cls_d = CLS_ALLMC;
      else if (is_group && mode.hash_en && hash_hit) cls_d = CLS_HASH;
      else                                       cls_d = CLS_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_class  <= CLS_NONE;
      end else begin
         dec_valid  <= last_byte;
         dec_accept <= last_byte && (cls_d != CLS_NONE);
         dec_class  <= last_byte ? cls_d : CLS_NONE;
      end
   end

   // R10
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!dec_accept && dec_class == CLS_NONE));

   // R9
   accept_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_accept == (dec_class != CLS_NONE)));

   // R5
   promisc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && mode.promisc) |=> (dec_accept && dec_class == CLS_PROMISC));

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
   import eth_rxf_pkg::*;
#(
   parameter int HASH_W     = 64,
   parameter int HREG_W     = 16,
   parameter int ADDR_BYTES = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_sel,
   input  logic [31:0] wr_data,
   input  logic        in_valid,
   input  logic        in_first,
   input  logic [7:0]  in_byte,
   output logic        dec_valid,
   output logic        dec_accept,
   output logic [2:0]  dec_class
);
   localparam int ADDR_W = ADDR_BYTES * 8;
   localparam int IDX_W  = $clog2(HASH_W);
   localparam int HREGS  = HASH_W / HREG_W;

   if (HASH_W != (1 << IDX_W) || IDX_W > 32)
      $error("HASH_W must be a power of two no wider than 2^32");
   if (HREGS * HREG_W != HASH_W || HREG_W > 32)
      $error("HASH_W must split into whole hash words of at most 32 bits");
   if (ADDR_BYTES != 6)
      $error("station register layout assumes a 6-byte address");
   if (HREGS + 3 > 8)
      $error("hash words do not fit the 3-bit register select");

   logic              last_byte;
   logic              frame_start;
   logic [ADDR_W-1:0] full_addr;
   logic [IDX_W-1:0]  crc_top;
   logic [ADDR_W-1:0] snap_station;
   rxf_mode_t         snap_mode;
   logic [HASH_W-1:0] snap_table;

   rxf_cfg_regs #(
      .HASH_W(HASH_W), .HREG_W(HREG_W), .ADDR_W(ADDR_W), .SEL_W(3), .DATA_W(32)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .snap_load(frame_start),
      .snap_station(snap_station), .snap_mode(snap_mode), .snap_table(snap_table)
   );

   rxf_crc_acc #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_crc (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_first(in_first), .in_byte(in_byte),
      .last_byte(last_byte), .frame_start(frame_start),
      .full_addr(full_addr), .crc_top(crc_top)
   );

   rxf_decide #(.ADDR_W(ADDR_W), .HASH_W(HASH_W), .IDX_W(IDX_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .last_byte(last_byte), .addr(full_addr), .crc_top(crc_top),
      .station(snap_station), .mode(snap_mode), .hash_table(snap_table),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_class(dec_class)
   );

endmodule

// File: tb/eth_rx_addr_filter_tb.sv
`timescale 1ns/1ps
module eth_rx_addr_filter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        in_valid = 1'b0;
   logic        in_first = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        dec_valid, dec_accept;
   logic [2:0]  dec_class;

   int vectors = 0;
   int miscomp = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   eth_rx_addr_filter u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .in_valid(in_valid), .in_first(in_first), .in_byte(in_byte),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_class(dec_class)
   );

   function automatic logic [31:0] ref_crc(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++) begin
         logic [7:0] d = a[47-8*b -: 8];
         for (int i = 0; i < 8; i++) begin
            logic fb = c[31] ^ d[i];
            c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
         end
      end
      return c;
   endfunction

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic set_station(input logic [47:0] a);
      wr(3'd0, {16'h0, a[47:32]});
      wr(3'd1, a[31:0]);
   endtask

   task automatic set_table(input logic [63:0] t);
      for (int r = 0; r < 4; r++) wr(3'(3 + r), {16'h0, t[63-16*r -: 16]});
   endtask

   task automatic check(input string tag, input logic v, input logic acc, input logic [2:0] cls,
                        input logic ev, input logic eacc, input logic [2:0] ecls);
      vectors++;
      if (v !== ev || acc !== eacc || cls !== ecls) begin
         miscomp++;
         $display("FAIL %s: got valid=%b accept=%b class=%0d, expected valid=%b accept=%b class=%0d",
                  tag, v, acc, cls, ev, eacc, ecls);
      end
   endtask

   task automatic send(input string tag, input logic [47:0] a, input logic eacc, input logic [2:0] ecls);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); in_valid = 1'b1; in_first = (i == 0); in_byte = a[47-8*i -: 8];
      end
      @(negedge clk); in_valid = 1'b0; in_first = 1'b0;
      check(tag, dec_valid, dec_accept, dec_class, 1'b1, eacc, ecls);
      @(negedge clk);
      check({tag, " R10 pulse end"}, dec_valid, dec_accept, dec_class, 1'b0, 1'b0, 3'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscomp++;
         $display("FAIL watchdog: got running, expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state and all-zero configuration
      check("R1 reset outputs", dec_valid, dec_accept, dec_class, 1'b0, 1'b0, 3'd0);
      send("R1 unicast after reset", 48'h0211_2233_4455, 1'b0, 3'd0);
      send("R1 broadcast after reset", 48'hFFFF_FFFF_FFFF, 1'b0, 3'd0);

      // R7 station match (R2 station layout)
      set_station(48'h0211_2233_4455);
      wr(3'd2, 32'h10);
      send("R7 station hit", 48'h0211_2233_4455, 1'b1, 3'd3);
      send("R7 last byte differs", 48'h0211_2233_4456, 1'b0, 3'd0);
      send("R7 first byte differs", 48'h0311_2233_4455, 1'b0, 3'd0);
      send("R7 middle byte differs", 48'h0211_22B3_4455, 1'b0, 3'd0);

      // R6 broadcast
      wr(3'd2, 32'h08);
      send("R6 broadcast hit", 48'hFFFF_FFFF_FFFF, 1'b1, 3'd2);
      send("R6 near broadcast", 48'hFFFF_FFFF_FFFE, 1'b0, 3'd0);

      // R5 promiscuous
      wr(3'd2, 32'h01);
      send("R5 promisc unicast", 48'h00AA_BBCC_DDEE, 1'b1, 3'd1);
      send("R5 promisc group", 48'h0100_5E7F_0001, 1'b1, 3'd1);

      // R8 all-multicast
      wr(3'd2, 32'h02);
      send("R8 allmc group", 48'h0100_5E01_0203, 1'b1, 3'd4);
      send("R8 allmc individual", 48'h0000_5E01_0203, 1'b0, 3'd0);

      // R9 priority
      wr(3'd2, 32'h1F);
      send("R9 promisc over all", 48'hFFFF_FFFF_FFFF, 1'b1, 3'd1);
      set_station(48'hFFFF_FFFF_FFFF);
      wr(3'd2, 32'h1A);
      send("R9 bcast over station", 48'hFFFF_FFFF_FFFF, 1'b1, 3'd2);
      set_station(48'h01AA_BBCC_DDEE);
      wr(3'd2, 32'h16);
      set_table(64'hFFFF_FFFF_FFFF_FFFF);
      send("R9 station over allmc", 48'h01AA_BBCC_DDEE, 1'b1, 3'd3);
      send("R9 allmc over hash", 48'h0100_5E00_0042, 1'b1, 3'd4);

      // R4 hash gating
      wr(3'd2, 32'h04);
      send("R4 hash ignores individual", 48'h0200_5E00_0042, 1'b0, 3'd0);
      wr(3'd2, 32'h00);
      send("R4 hash off", 48'h0100_5E00_0042, 1'b0, 3'd0);

      // R3 sweep of 64 multicast addresses
      wr(3'd2, 32'h04);
      for (int k = 0; k < 64; k++) begin
         logic [47:0] a = 48'h0100_5E00_0000 | 48'(k * 37);
         logic [31:0] c = ref_crc(a);
         int idx = 63 - int'(c[31:26]);
         logic [15:0] w [4];
         logic [63:0] t;
         for (int r = 0; r < 4; r++) w[r] = (r == idx / 16) ? (16'h8000 >> (idx % 16)) : 16'h0;
         t = {w[0], w[1], w[2], w[3]};
         set_table(t);
         send($sformatf("R3 hash hit idx %0d", idx), a, 1'b1, 3'd5);
         set_table(~t);
         send($sformatf("R3 hash miss idx %0d", idx), a, 1'b0, 3'd0);
      end

      // R11 mid-frame write does not apply to the current frame
      wr(3'd2, 32'h00);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); in_valid = 1'b1; in_first = (i == 0);
         in_byte = 8'(48'h0233_4455_6677 >> (40 - 8*i));
      end
      @(negedge clk); in_valid = 1'b0; in_first = 1'b0;
      wr(3'd2, 32'h01);
      for (int i = 3; i < 6; i++) begin
         @(negedge clk); in_valid = 1'b1;
         in_byte = 8'(48'h0233_4455_6677 >> (40 - 8*i));
         if (i == 5) check("R10 no strobe before sixth byte", dec_valid, dec_accept, dec_class,
                           1'b0, 1'b0, 3'd0);
      end
      @(negedge clk); in_valid = 1'b0;
      check("R11 frozen config", dec_valid, dec_accept, dec_class, 1'b1, 1'b0, 3'd0);
      send("R11 next frame uses write", 48'h0233_4455_6677, 1'b1, 3'd1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end
endmodule